// File: doc/BRIEF.md
# Broadcast CRC and Tail-Biting Encoder

This block takes a fixed-length system information word, 24 bits arriving serially one bit per accepted `valid_i`. It computes a 16-bit CRC over the word and XORs that CRC with a mask. The mask depends on how many transmit antennas are configured. The masked CRC is appended to form a 40-bit block.

The 40-bit block is then fed through a rate-1/3, constraint-length-7 convolutional encoder. The encoder is tail-biting: it starts from the state formed by the last six block bits, so its end state equals its start state and no tail bits are needed. The three coded bits of every block bit leave one per clock on a single serial output. Each bit produces three output cycles, so the output runs at three times the rate of the information bits. Each block yields exactly 120 coded bits, framed by start and end markers. One block is produced per 40 ms broadcast interval, so the block never has to accept a new word while it is still emitting the previous one.

Top module: `bch_crc_tbcc_enc`

## Requirements
- R1: After reset, and until a complete word has been taken in, `valid_o`, `sop_o` and `eop_o` are low.
- R2: The CRC uses polynomial x^16+x^12+x^5+1 (0x1021) with an all-zero start value. It is computed over the 24 data bits, taken in arrival order. Block bit c[i] for i<24 is the i-th accepted data bit. Bits c[24..39] are the CRC, highest-order bit first, each XORed with the mask bit of equal order.
- R3: `ant_sel_i` picks the mask, written highest-order bit first: 2'b00 (one antenna) gives 0x0000, 2'b01 (two antennas) gives 0xFFFF, 2'b10 (four antennas) gives 0x5555 (so c[24]=0, c[25]=1, ..., c[39]=1), and 2'b11 gives 0x0000. The select is sampled only with the start bit; later changes have no effect on that block.
- R4: The encoder uses constraint length 7 with generators 133, 171 and 165 (octal). For a generator g, the output for block bit k is the XOR over j=0..6 of g[6-j]&c[(k-j) mod 40]. This makes the initial state c[39..34].
- R5: Output bit 3k+r (r=0,1,2) is the output of generator r (133, 171, 165) for block bit k, emitted in that order.
- R6: Each block yields exactly 120 consecutive cycles with `valid_o` high. `sop_o` is high on the first of them only, `eop_o` on the last only, and `valid_o` drops on the cycle after `eop_o`.
- R7: If the 24th data bit is sampled at rising edge N, the first coded bit (with `sop_o`) is presented from edge N+1 to edge N+2.
- R8: `valid_i` with `start_i` high always starts a new word and discards any partial word. While no word is being collected, `valid_i` without `start_i` is ignored.
- R9: From the edge that samples the 24th bit until the edge that leaves `eop_o`, all inputs, including `start_i`, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, at the coded-bit rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Marks the first bit of a word, qualified by valid_i |
| data_i | input | 1 | Serial word bit |
| valid_i | input | 1 | Input bit qualifier |
| ant_sel_i | input | 2 | Transmit antenna count select, sampled with the start bit |
| bit_o | output | 1 | Serial coded bit |
| valid_o | output | 1 | Coded bit qualifier |
| sop_o | output | 1 | First coded bit of a block |
| eop_o | output | 1 | Last coded bit of a block |

## Verification
The assertions assume the block is only loaded when the encoder is idle. They also assume that a finished word is handed over in a single-cycle pulse. Input activity during emission is allowed, since the design must ignore it. The stimulus therefore drives random `valid_i`, `start_i`, `data_i` and `ant_sel_i` values throughout the emission window. It also puts idle bits without a start, and abandoned partial words, ahead of real words. The antenna select is changed randomly after each start bit, so that only the sampled value can shape the mask.

// File: rtl/bch_enc_pkg.sv
package bch_enc_pkg;
  localparam int unsigned INFO_BITS = 24;
  localparam int unsigned CRC_BITS  = 16;
  localparam int unsigned CONST_LEN = 7;
  localparam int unsigned CODE_RATE = 3;
  localparam logic [CRC_BITS-1:0] CRC_POLY = 16'h1021;
  // generator r lives at bits [r*CONST_LEN +: CONST_LEN], emitted r = 0 first
  localparam logic [CODE_RATE*CONST_LEN-1:0] GEN_SET = {7'o165, 7'o171, 7'o133};

  typedef enum logic [1:0] {
    ANT_ONE  = 2'b00,
    ANT_TWO  = 2'b01,
    ANT_FOUR = 2'b10,
    ANT_RSVD = 2'b11
  } ant_cfg_e;
endpackage

// File: rtl/bch_crc_serial.sv
module bch_crc_serial #(
  parameter int unsigned          W    = 16,
  parameter logic [W-1:0]         POLY = 16'h1021
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q, base, crc_nxt;
  logic         fb;

  always_comb begin
    base    = clr_i ? '0 : crc_q;
    fb      = bit_i ^ base[W-1];
    crc_nxt = {base[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= '0;
    else if (en_i) crc_q <= crc_nxt;
  end

  assign crc_o = crc_q;

  AST_CRC_ZERO_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && clr_i && !bit_i) |=> (crc_o == '0)); // R2
endmodule

// File: rtl/bch_blk_collect.sv
module bch_blk_collect
  import bch_enc_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CRC_W  = 16,
  localparam int unsigned BLK_W = DATA_W + CRC_W,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             data_i,
  input  logic             valid_i,
  input  logic [1:0]       ant_i,
  input  logic             busy_i,
  input  logic [CRC_W-1:0] crc_i,
  output logic             crc_clr_o,
  output logic             crc_en_o,
  output logic             done_o,
  output logic [BLK_W-1:0] blk_o
);
  logic              act_q, done_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [DATA_W-1:0] data_q;
  logic [CRC_W-1:0]  mask_q, mask_sel, crc_m;
  logic              take, first, acc;

  // mask in CRC bit order (bit CRC_W-1 goes out first)
  always_comb begin
    mask_sel = '0;
    unique case (ant_cfg_e'(ant_i))
      ANT_TWO:  mask_sel = '1;
      ANT_FOUR: for (int i = 0; i < int'(CRC_W); i++) mask_sel[i] = (i % 2 == 0);
      default:  mask_sel = '0;
    endcase
  end

  assign take    = valid_i && !busy_i && !done_q;
  assign first   = take && start_i;
  assign acc     = take && (start_i || act_q);
  assign cnt_nxt = first ? CNT_W'(1) : cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (acc) begin
        data_q <= {data_i, data_q[DATA_W-1:1]};
        if (first) mask_q <= mask_sel;
        if (cnt_nxt == CNT_W'(DATA_W)) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          act_q  <= 1'b1;
          cnt_q  <= cnt_nxt;
        end
      end
    end
  end

  assign crc_m = crc_i ^ mask_q;

  always_comb begin
    blk_o[DATA_W-1:0] = data_q;
    for (int m = 0; m < int'(CRC_W); m++) blk_o[DATA_W+m] = crc_m[CRC_W-1-m];
  end

  assign crc_clr_o = first;
  assign crc_en_o  = acc;
  assign done_o    = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_HOLD_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i || done_o) |=> ($stable(data_q) && $stable(mask_q))); // R9
endmodule

// File: rtl/bch_tbcc_ser.sv
module bch_tbcc_ser #(
  parameter int unsigned BLK_W = 40,
  parameter int unsigned K     = 7,
  parameter int unsigned RATE  = 3,
  parameter logic [RATE*K-1:0] GENS = {7'o165, 7'o171, 7'o133},
  localparam int unsigned M     = K - 1,
  localparam int unsigned OUT_N = BLK_W * RATE,
  localparam int unsigned CNT_W = $clog2(OUT_N),
  localparam int unsigned SUB_W = (RATE > 1) ? $clog2(RATE) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             bit_o,
  output logic             valid_o,
  output logic             sop_o,
  output logic             eop_o,
  output logic             busy_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SUB_W-1:0] sub_q;
  logic [BLK_W-1:0] feed_q;
  logic [M-1:0]     sr_q;   // sr_q[M-1] is the most recent past bit
  logic [K-1:0]     taps;
  logic [RATE-1:0]  coded;

  assign taps = {feed_q[0], sr_q};

  for (genvar r = 0; r < int'(RATE); r++) begin : g_gen
    assign coded[r] = ^(GENS[r*K +: K] & taps);
  end

  assign bit_o   = coded[sub_q];
  assign valid_o = run_q;
  assign sop_o   = run_q && (cnt_q == '0);
  assign eop_o   = run_q && (cnt_q == CNT_W'(OUT_N - 1));
  assign busy_o  = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      sub_q  <= '0;
      feed_q <= '0;
      sr_q   <= '0;
    end else if (!run_q) begin
      if (load_i) begin
        run_q  <= 1'b1;
        cnt_q  <= '0;
        sub_q  <= '0;
        feed_q <= blk_i;
        sr_q   <= blk_i[BLK_W-1 -: M];  // tail-biting start state
      end
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (eop_o) run_q <= 1'b0;
      if (sub_q == SUB_W'(RATE - 1)) begin
        sub_q  <= '0;
        feed_q <= {1'b0, feed_q[BLK_W-1:1]};
        sr_q   <= {feed_q[0], sr_q[M-1:1]};
      end else begin
        sub_q  <= sub_q + SUB_W'(1);
      end
    end
  end

  AST_CONTIG_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !eop_o) |=> valid_o); // R6
  AST_EOP_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |=> !valid_o); // R6
  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_o); // R9
  AST_LOAD_TO_SOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sop_o); // R7
endmodule

// File: rtl/bch_crc_tbcc_enc.sv
module bch_crc_tbcc_enc
  import bch_enc_pkg::*;
#(
  parameter int unsigned DATA_W = INFO_BITS,
  parameter int unsigned CRC_W  = CRC_BITS,
  parameter logic [CRC_W-1:0] POLY = CRC_POLY,
  parameter int unsigned K      = CONST_LEN,
  parameter int unsigned RATE   = CODE_RATE,
  parameter logic [RATE*K-1:0] GENS = GEN_SET,
  localparam int unsigned BLK_W = DATA_W + CRC_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       data_i,
  input  logic       valid_i,
  input  logic [1:0] ant_sel_i,
  output logic       bit_o,
  output logic       valid_o,
  output logic       sop_o,
  output logic       eop_o
);
  logic             crc_clr, crc_en, blk_done, enc_busy;
  logic [CRC_W-1:0] crc_val;
  logic [BLK_W-1:0] blk;

  bch_crc_serial #(.W(CRC_W), .POLY(POLY)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (crc_clr),
    .en_i   (crc_en),
    .bit_i  (data_i),
    .crc_o  (crc_val)
  );

  bch_blk_collect #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_collect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .data_i    (data_i),
    .valid_i   (valid_i),
    .ant_i     (ant_sel_i),
    .busy_i    (enc_busy),
    .crc_i     (crc_val),
    .crc_clr_o (crc_clr),
    .crc_en_o  (crc_en),
    .done_o    (blk_done),
    .blk_o     (blk)
  );

  bch_tbcc_ser #(.BLK_W(BLK_W), .K(K), .RATE(RATE), .GENS(GENS)) u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (blk_done),
    .blk_i   (blk),
    .bit_o   (bit_o),
    .valid_o (valid_o),
    .sop_o   (sop_o),
    .eop_o   (eop_o),
    .busy_o  (enc_busy)
  );
endmodule

// File: tb/bch_crc_tbcc_enc_tb.sv
module bch_crc_tbcc_enc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int NBITS      = 24;
  localparam int NOUT       = 120;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, data_i = 0, valid_i = 0;
  logic [1:0] ant_sel_i = 0;
  logic bit_o, valid_o, sop_o, eop_o;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bch_crc_tbcc_enc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .data_i(data_i),
    .valid_i(valid_i), .ant_sel_i(ant_sel_i), .bit_o(bit_o),
    .valid_o(valid_o), .sop_o(sop_o), .eop_o(eop_o)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_ref(input logic [23:0] d);
    logic [15:0] c = '0;
    for (int i = 0; i < NBITS; i++) begin
      logic fb = d[i] ^ c[15];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [15:0] mask_ref(input logic [1:0] a);
    case (a)
      2'b01:   return 16'hFFFF;
      2'b10:   return 16'h5555;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [39:0] blk_ref(input logic [23:0] d, input logic [1:0] a);
    logic [39:0] b;
    logic [15:0] cm = crc_ref(d) ^ mask_ref(a);
    b[23:0] = d;
    for (int m = 0; m < 16; m++) b[24+m] = cm[15-m];
    return b;
  endfunction

  function automatic logic [119:0] coded_ref(input logic [39:0] b);
    logic [6:0] g [3] = '{7'o133, 7'o171, 7'o165};
    logic [119:0] o;
    for (int n = 0; n < NOUT; n++) begin
      int k = n / 3;
      logic x = 1'b0;
      for (int j = 0; j < 7; j++) x ^= g[n % 3][6-j] & b[(k - j + 40) % 40];
      o[n] = x;
    end
    return o;
  endfunction

  // pre_junk: valid bits without start while idle; partial: abandoned word length
  task automatic run_block(input logic [23:0] d, input logic [1:0] a, input int gap_max,
                           input int pre_junk, input int partial, input bit noisy, input string name);
    logic [119:0] got = '0, exp;
    int sop_bad = 0, eop_bad = 0, val_bad = 0;
    exp = coded_ref(blk_ref(d, a));
    for (int i = 0; i < pre_junk; i++) begin
      @(negedge clk); valid_i = 1; start_i = 0; data_i = 1'($urandom); ant_sel_i = 2'($urandom);
    end
    for (int i = 0; i < partial; i++) begin
      @(negedge clk); valid_i = 1; start_i = (i == 0); data_i = 1'($urandom); ant_sel_i = 2'($urandom);
    end
    for (int i = 0; i < NBITS; i++) begin
      int gap = (gap_max > 0) ? int'($urandom_range(gap_max, 0)) : 0;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); valid_i = 0; start_i = 1'($urandom); data_i = 1'($urandom);
      end
      @(negedge clk);
      valid_i = 1; start_i = (i == 0); data_i = d[i];
      ant_sel_i = (i == 0) ? a : 2'($urandom);  // R3: later select changes ignored
    end
    fork
      begin
        for (int j = 1; j <= 121; j++) begin
          @(negedge clk);
          if (noisy && j < 121) begin
            valid_i = 1'($urandom); start_i = 1'($urandom);
            data_i = 1'($urandom); ant_sel_i = 2'($urandom);
          end else begin
            valid_i = 0; start_i = 0; data_i = 0;
          end
        end
      end
      begin
        @(negedge clk);
        check(!valid_o, {"R7 no output one cycle after last bit ", name}, 128'(valid_o), 128'(0));
        for (int n = 0; n < NOUT; n++) begin
          @(negedge clk);
          if (n == 0) check(valid_o && sop_o, {"R7 first coded bit with sop ", name},
                            128'({valid_o, sop_o}), 128'(2'b11));
          got[n] = bit_o;
          if (!valid_o) val_bad++;
          if (sop_o != (n == 0)) sop_bad++;
          if (eop_o != (n == NOUT-1)) eop_bad++;
        end
        check(got == exp, {"R2 R4 R5 coded stream ", name}, 128'(got), 128'(exp));
        check(val_bad == 0 && sop_bad == 0 && eop_bad == 0, {"R6 framing ", name},
              128'({val_bad[7:0], sop_bad[7:0], eop_bad[7:0]}), 128'(0));
        @(negedge clk);
        check(!valid_o && !sop_o && !eop_o, {"R6 valid drops after eop ", name},
              128'({valid_o, sop_o, eop_o}), 128'(0));
      end
    join
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1b2c3d4e));
    repeat (3) @(negedge clk);
    check(!valid_o && !sop_o && !eop_o, "R1 outputs low in reset", 128'({valid_o, sop_o, eop_o}), 128'(0));
    rst_n = 1'b1;
    // R8: idle valid bits without start must not produce output
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); valid_i = 1; start_i = 0; data_i = 1'($urandom);
    end
    @(negedge clk); valid_i = 0;
    repeat (4) @(negedge clk);
    check(!valid_o, "R1 R8 no output before a started word", 128'(valid_o), 128'(0));

    run_block(24'h000000, 2'b00, 0, 0, 0, 0, "zeros one-ant");
    run_block(24'hFFFFFF, 2'b01, 0, 0, 0, 0, "ones two-ant R3");
    run_block(24'hA5C30F, 2'b10, 0, 0, 0, 0, "four-ant R3");
    run_block(24'h123456, 2'b11, 1, 0, 0, 0, "reserved sel R3");
    run_block(24'h800001, 2'b10, 0, 5, 0, 1, "junk then word R8 R9");
    run_block(24'h5A5A5A, 2'b01, 2, 0, 23, 1, "restart after 23 bits R8");
    run_block(24'hC0FFEE, 2'b00, 3, 2, 1, 1, "restart after 1 bit R8");
    for (int t = 0; t < 30; t++) begin
      run_block(24'($urandom), 2'($urandom), int'($urandom_range(3, 0)),
                int'($urandom_range(4, 0)), int'($urandom_range(20, 0)),
                1'($urandom), "random");
    end
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule